// File: doc/BRIEF.md
# Conversion Restart Interrupt Hold-Off

This block sits beside a multi-channel sigma-delta converter and decides, one channel at a time, whether a finished conversion may raise an interrupt. After a channel is restarted, or has its amplifier gain or its input selection changed, the first few results come out of a decimation filter that has not yet settled. The block holds back interrupts for those results.

Each channel has a small down-counter that measures the hold-off in completed conversions, not in clock cycles. A restart, gain change or input change loads the counter from that channel's programmed hold-off code. Each conversion-done pulse that arrives while the counter is above zero is swallowed and moves the counter down by one. Once the counter reaches zero, done pulses pass through as result-interrupt qualifiers, and the overflow-interrupt enable for that channel goes high.

Flag storage, vector priority and the filter itself live elsewhere. This block only counts conversions and gates requests.

Top module: `cid_conv_irq_delay`

## Requirements
- R1: A synchronous reset loads every channel's counter from its hold-off code. Right after reset, `ovf_irq_en[c]` is 1 only for channels whose code is 0.
- R2: With hold-off code k (2 bits, channel c at bits `[2c+1:2c]` of `dly_code`, values 0..3), the first k done pulses after an arming event give `res_irq_ok[c]`=0. The (k+1)-th done pulse gives `res_irq_ok[c]`=1 in the same cycle.
- R3: `ovf_irq_en[c]` is 0 while the channel's hold-off is still counting and 1 once it has expired. `res_irq_ok[c]` is never 1 while `ovf_irq_en[c]` is 0.
- R4: A pulse on `start_stb[c]` re-arms channel c from its current code.
- R5: A pulse on `gain_stb[c]` re-arms channel c from its current code.
- R6: A pulse on `insel_stb[c]` re-arms channel c from its current code.
- R7: A re-arm that arrives while a hold-off is partly counted reloads the full count. Earlier swallowed conversions are not credited.
- R8: A done pulse in the same cycle as a re-arm is swallowed (`res_irq_ok`=0). It does not decrement the freshly loaded count.
- R9: Once open, a channel passes every later done pulse until the next re-arm.
- R10: Events on one channel never change the qualifiers of another channel.
- R11: Changing `dly_code` without a re-arm leaves the running state unchanged. The new code takes effect at the next re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dly_code | input | N_CH*CODE_W | Per-channel hold-off code, channel c in bits [CODE_W*c +: CODE_W] |
| start_stb | input | N_CH | Start-conversion strobe per channel |
| gain_stb | input | N_CH | Gain-setting change strobe per channel |
| insel_stb | input | N_CH | Input-select change strobe per channel |
| conv_done | input | N_CH | Conversion-done pulse per channel |
| res_irq_ok | output | N_CH | Done pulse qualified for a result interrupt |
| ovf_irq_en | output | N_CH | Overflow interrupt enable (hold-off expired) |

## Verification
The bench drives all four code values side by side, so an off-by-one in the code-to-count mapping shows up as one channel passing a conversion early or late. It re-arms a channel halfway through its count and expects the whole count again. A design that only resumed the old count would pass the result too soon. A re-arm that lands on the same cycle as a done pulse must swallow that pulse and keep the full count; a design that decremented the count at that point would open one conversion early. The bench also changes the code with no re-arm, and it strobes gain or input on a single channel while watching the others, to catch a design that loads the code continuously or lets events leak between channels.

// File: rtl/cid_pkg.sv
package cid_pkg;

    typedef struct packed {
        logic start;
        logic gain;
        logic insel;
        logic done;
    } chan_evt_t;

    typedef struct packed {
        logic res_ok;
        logic ovf_en;
    } chan_qual_t;

    function automatic logic evt_rearms(input chan_evt_t e);
        return e.start | e.gain | e.insel;
    endfunction

endpackage

// File: rtl/cid_rearm.sv
module cid_rearm
    import cid_pkg::*;
(
    input  chan_evt_t evt,
    output logic      rearm,
    output logic      done
);
    always_comb begin
        rearm = evt_rearms(evt);
        done  = evt.done;
    end
endmodule

// File: rtl/cid_counter.sv
module cid_counter #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              rearm,
    input  logic              done,
    output logic              open
);
    logic [CODE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= code;
        end else if (rearm) begin
            cnt_q <= code;
        end else if (done && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign open = (cnt_q == '0);
endmodule

// File: rtl/cid_gate.sv
module cid_gate
    import cid_pkg::*;
(
    input  logic       open,
    input  logic       rearm,
    input  logic       done,
    output chan_qual_t qual
);
    always_comb begin
        qual.res_ok = done & open & ~rearm;
        qual.ovf_en = open;
    end
endmodule

// File: rtl/cid_conv_irq_delay.sv
module cid_conv_irq_delay
    import cid_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int CODE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_CH*CODE_W-1:0]   dly_code,
    input  logic [N_CH-1:0]          start_stb,
    input  logic [N_CH-1:0]          gain_stb,
    input  logic [N_CH-1:0]          insel_stb,
    input  logic [N_CH-1:0]          conv_done,
    output logic [N_CH-1:0]          res_irq_ok,
    output logic [N_CH-1:0]          ovf_irq_en
);
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        chan_evt_t  evt;
        chan_qual_t qual;
        logic       rearm;
        logic       done;
        logic       open;

        always_comb begin
            evt.start = start_stb[c];
            evt.gain  = gain_stb[c];
            evt.insel = insel_stb[c];
            evt.done  = conv_done[c];
        end

        cid_rearm u_rearm (
            .evt   (evt),
            .rearm (rearm),
            .done  (done)
        );

        cid_counter #(.CODE_W(CODE_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .code  (dly_code[c*CODE_W +: CODE_W]),
            .rearm (rearm),
            .done  (done),
            .open  (open)
        );

        cid_gate u_gate (
            .open  (open),
            .rearm (rearm),
            .done  (done),
            .qual  (qual)
        );

        assign res_irq_ok[c] = qual.res_ok;
        assign ovf_irq_en[c] = qual.ovf_en;
    end
endmodule

// File: rtl/cid_checker.sv
module cid_checker #(
    parameter int N_CH   = 4,
    parameter int CODE_W = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N_CH*CODE_W-1:0] dly_code,
    input logic [N_CH-1:0]        start_stb,
    input logic [N_CH-1:0]        gain_stb,
    input logic [N_CH-1:0]        insel_stb,
    input logic [N_CH-1:0]        conv_done,
    input logic [N_CH-1:0]        res_irq_ok,
    input logic [N_CH-1:0]        ovf_irq_en
);
    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        logic rearm;
        assign rearm = start_stb[c] | gain_stb[c] | insel_stb[c];

        p_res_needs_gate_r3: assert property (@(posedge clk) disable iff (rst)
            res_irq_ok[c] |-> (ovf_irq_en[c] && conv_done[c]));

        p_rearm_closes_r7: assert property (@(posedge clk) disable iff (rst)
            (rearm && dly_code[c*CODE_W +: CODE_W] != '0) |=> !ovf_irq_en[c]);

        p_coincide_swallow_r8: assert property (@(posedge clk) disable iff (rst)
            (rearm && conv_done[c]) |-> !res_irq_ok[c]);

        p_stay_open_r9: assert property (@(posedge clk) disable iff (rst)
            (ovf_irq_en[c] && !rearm) |=> ovf_irq_en[c]);

        p_closed_hold_r2: assert property (@(posedge clk) disable iff (rst)
            (!ovf_irq_en[c] && !rearm && !conv_done[c]) |=> !ovf_irq_en[c]);
    end
endmodule

bind cid_conv_irq_delay cid_checker #(.N_CH(N_CH), .CODE_W(CODE_W)) u_cid_checker (
    .clk        (clk),
    .rst        (rst),
    .dly_code   (dly_code),
    .start_stb  (start_stb),
    .gain_stb   (gain_stb),
    .insel_stb  (insel_stb),
    .conv_done  (conv_done),
    .res_irq_ok (res_irq_ok),
    .ovf_irq_en (ovf_irq_en)
);

// File: tb/cid_conv_irq_delay_bench.sv
module cid_conv_irq_delay_bench;
    localparam int N = 4;
    localparam int W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N*W-1:0] dly_code = 8'b11_10_01_00;
    logic [N-1:0] start_stb = '0, gain_stb = '0, insel_stb = '0, conv_done = '0;
    logic [N-1:0] res_irq_ok, ovf_irq_en;
    logic [N-1:0] obs_res, obs_ovf;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    cid_conv_irq_delay #(.N_CH(N), .CODE_W(W)) u_cid_conv_irq_delay (
        .clk(clk), .rst(rst), .dly_code(dly_code),
        .start_stb(start_stb), .gain_stb(gain_stb), .insel_stb(insel_stb),
        .conv_done(conv_done), .res_irq_ok(res_irq_ok), .ovf_irq_en(ovf_irq_en)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus from a negedge, sample before the edge,
    // then return at the following negedge with the inputs cleared.
    task automatic cyc(input logic [N-1:0] d, input logic [N-1:0] s,
                       input logic [N-1:0] g, input logic [N-1:0] i);
        conv_done = d; start_stb = s; gain_stb = g; insel_stb = i;
        #1;
        obs_res = res_irq_ok;
        obs_ovf = ovf_irq_en;
        @(negedge clk);
        conv_done = '0; start_stb = '0; gain_stb = '0; insel_stb = '0;
    endtask

    task automatic open_all();
        for (int j = 0; j < 4; j++) cyc('1, '0, '0, '0);
    endtask

    task automatic t_reset();
        chk("R1 ovf_irq_en after reset", ovf_irq_en, 4'b0001);
        chk("R1 res_irq_ok idle after reset", res_irq_ok, 4'b0000);
    endtask

    task automatic t_delay();
        logic [N-1:0] exp;
        for (int j = 0; j < 5; j++) begin
            exp = '0;
            for (int c = 0; c < N; c++) if (j >= c) exp[c] = 1'b1;
            cyc('1, '0, '0, '0);
            chk("R2 res_irq_ok per code", obs_res, exp);
            chk("R3 ovf_irq_en per code", obs_ovf, exp);
        end
        cyc('1, '0, '0, '0);
        chk("R9 stays open", obs_res, 4'b1111);
    endtask

    task automatic t_start();
        open_all();
        cyc('0, '1, '0, '0);
        cyc('0, '0, '0, '0);
        chk("R4 start rearms all", obs_ovf, 4'b0001);
        cyc('1, '0, '0, '0);
        chk("R4 first done after start", obs_res, 4'b0001);
    endtask

    task automatic t_gain();
        open_all();
        cyc('0, '0, 4'b0100, '0);
        cyc('0, '0, '0, '0);
        chk("R5 gain rearms ch2 only", obs_ovf, 4'b1011);
        cyc(4'b1111, '0, '0, '0);
        chk("R10 others unaffected", obs_res, 4'b1011);
        cyc(4'b0100, '0, '0, '0);
        chk("R5 second done swallowed", obs_res, 4'b0000);
        cyc(4'b0100, '0, '0, '0);
        chk("R5 third done passes", obs_res, 4'b0100);
    endtask

    task automatic t_insel();
        open_all();
        cyc('0, '0, '0, 4'b1000);
        cyc('0, '0, '0, '0);
        chk("R6 insel rearms ch3 only", obs_ovf, 4'b0111);
        for (int j = 0; j < 3; j++) begin
            cyc(4'b1000, '0, '0, '0);
            chk("R6 done swallowed", obs_res, 4'b0000);
        end
        cyc(4'b1000, '0, '0, '0);
        chk("R6 fourth done passes", obs_res, 4'b1000);
    endtask

    task automatic t_reload();
        open_all();
        cyc('0, 4'b1000, '0, '0);
        cyc(4'b1000, '0, '0, '0);
        cyc(4'b1000, '0, '0, '0);
        cyc('0, 4'b1000, '0, '0);
        for (int j = 0; j < 3; j++) begin
            cyc(4'b1000, '0, '0, '0);
            chk("R7 full count reloaded", obs_res, 4'b0000);
        end
        cyc(4'b1000, '0, '0, '0);
        chk("R7 pass after full reload", obs_res, 4'b1000);
    endtask

    task automatic t_coincide();
        open_all();
        cyc(4'b0011, 4'b0011, '0, '0);
        chk("R8 done with rearm swallowed", obs_res, 4'b0000);
        cyc(4'b0011, '0, '0, '0);
        chk("R8 no decrement on coincide", obs_res, 4'b0001);
        cyc(4'b0011, '0, '0, '0);
        chk("R8 ch1 opens after one", obs_res, 4'b0011);
    endtask

    task automatic t_cfg();
        open_all();
        dly_code[1:0] = 2'd3;
        cyc(4'b0001, '0, '0, '0);
        chk("R11 code change alone no effect", obs_res, 4'b0001);
        cyc('0, 4'b0001, '0, '0);
        cyc('0, '0, '0, '0);
        chk("R11 new code used on rearm", obs_ovf, 4'b1110);
        for (int j = 0; j < 3; j++) cyc(4'b0001, '0, '0, '0);
        chk("R11 still closed before fourth", obs_res, 4'b0000);
        cyc(4'b0001, '0, '0, '0);
        chk("R11 fourth passes", obs_res, 4'b0001);
        dly_code[1:0] = 2'd0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_delay();
        t_start();
        t_gain();
        t_insel();
        t_reload();
        t_coincide();
        t_cfg();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule